// File: doc/BRIEF.md
# Vectored Priority Nesting Unit

This unit turns a word of already-masked pending interrupt sources into a single IRQ request. It does so against a priority that follows the software's nesting of handlers. Sixteen vector slots each bind one of 32 sources to a 32-bit handler address. Slot index sets the priority, and index 0 is the most urgent. A seventeenth, default level catches any pending source that no enabled slot claims. A further idle level, above all the others, is the state when no handler is running.

A handler starts by reading the vector register. That read returns the address of the most urgent pending level above the one now running. It also makes that level current and stores the level it replaced in a per-level save table. The handler ends by writing any value to the same register, which brings back the saved level. Handlers can therefore nest to any depth the levels allow. IRQ is raised only while some pending source maps to a level more urgent than the current one.

Top module: `vec_prio_ctrl`

## Requirements
- R1: Levels are ordered by slot index with 0 most urgent. The search picks the lowest-index enabled slot whose source is pending. A source of a less urgent or equal slot raises no IRQ while a more urgent handler runs.
- R2: A slot control word holds the enable in bit 5 and the source number in bits 4:0. A slot whose enable is clear maps nothing, so its source can only reach the default level.
- R3: irq_o is high when some pending source maps to a level more urgent than the current one. At the idle level (17), any pending bit raises irq_o. At the default level (16), only sources of enabled slots raise it.
- R4: A read of offset 0x30 that finds a more urgent pending level returns that level's address, which is the default address for level 16. The read makes that level current and saves the previous level for it.
- R5: A read of offset 0x30 that finds no more urgent pending level returns the default address and leaves the current level unchanged.
- R6: Any write to offset 0x30 replaces the current level with the one saved for it. At the idle level such a write has no effect.
- R7: Slot addresses are at 0x100 + 4*n and slot control words at 0x200 + 4*n. The default address is at 0x34. Each reads back what was written, and read data appears on rdata_o the cycle after the request.
- R8: After reset, irq_o is low with no pending sources and the current level is idle. All slot addresses, control words and the default address read as zero.
- R9: A control write takes effect on the IRQ decision and the vector search from the next cycle on.
- R10: If two enabled slots name the same source, the lower-index slot is the one selected.
- R11: A vector read uses the pending word present at the same clock edge as the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | 32 | Masked pending source word |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
Two events can meet on one clock edge: a vector read and a change of the pending word. The bench provokes this by raising a pending bit in the same cycle as the read strobe. The read is correct only if it returns the slot address that the new pending word selects, and not the default. A second overlap is a control rewrite while a nested handler is active. The bench judges it by irq_o, which must rise on the very next cycle, and by the next vector read, which must return the remapped slot.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned SRC_FLDW = 5;

  localparam logic [ADDR_W-1:0] OFS_VECT  = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_DFLT  = 12'h034;
  localparam logic [ADDR_W-1:0] BASE_ADDR = 12'h100;
  localparam logic [ADDR_W-1:0] BASE_CTRL = 12'h200;

  typedef struct packed {
    logic                en;
    logic [SRC_FLDW-1:0] src;
  } slot_ctrl_t;
endpackage

// File: rtl/vpc_mask_gen.sv
module vpc_mask_gen
  import vpc_pkg::*;
#(
  parameter int unsigned NUM_SLOT = 16,
  parameter int unsigned NUM_SRC  = 32
) (
  input  slot_ctrl_t [NUM_SLOT-1:0]                ctrl_i,
  output logic       [NUM_SLOT+1:0][NUM_SRC-1:0]   masks_o
);
  logic [NUM_SLOT-1:0][NUM_SRC-1:0] contrib;

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_contrib
    assign contrib[g] = ctrl_i[g].en ? (NUM_SRC'(1) << ctrl_i[g].src) : '0;
  end

  // level i covers sources of enabled slots below i; idle level covers all
  always_comb begin
    logic [NUM_SRC-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_SLOT; i++) begin
      masks_o[i] = acc;
      acc = acc | contrib[i];
    end
    masks_o[NUM_SLOT]   = acc;
    masks_o[NUM_SLOT+1] = '1;
  end
endmodule

// File: rtl/vpc_level_pick.sv
module vpc_level_pick #(
  parameter int unsigned NUM_SLOT = 16,
  parameter int unsigned NUM_SRC  = 32,
  localparam int unsigned LVL_W   = $clog2(NUM_SLOT + 2)
) (
  input  logic [NUM_SRC-1:0]                pend_i,
  input  logic [NUM_SLOT+1:0][NUM_SRC-1:0]  masks_i,
  input  logic [LVL_W-1:0]                  cur_i,
  output logic                              found_o,
  output logic [LVL_W-1:0]                  lvl_o,
  output logic                              irq_o
);
  always_comb begin
    found_o = 1'b0;
    lvl_o   = LVL_W'(NUM_SLOT + 1);
    for (int i = 0; i <= NUM_SLOT; i++) begin
      if (!found_o && (|(pend_i & masks_i[i+1])) && (LVL_W'(i) < cur_i)) begin
        found_o = 1'b1;
        lvl_o   = LVL_W'(i);
      end
    end
  end

  assign irq_o = |(pend_i & masks_i[cur_i]);
endmodule

// File: rtl/vpc_prio_stack.sv
module vpc_prio_stack #(
  parameter int unsigned NUM_SLOT = 16,
  localparam int unsigned LVL_W   = $clog2(NUM_SLOT + 2),
  localparam int unsigned IDLE    = NUM_SLOT + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raise_i,
  input  logic [LVL_W-1:0] raise_lvl_i,
  input  logic             restore_i,
  output logic [LVL_W-1:0] cur_o
);
  logic [LVL_W-1:0] cur_q;
  logic [LVL_W-1:0] saved_q [NUM_SLOT+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= LVL_W'(IDLE);
      for (int i = 0; i <= NUM_SLOT; i++) saved_q[i] <= LVL_W'(IDLE);
    end else if (raise_i) begin
      saved_q[raise_lvl_i] <= cur_q;
      cur_q                <= raise_lvl_i;
    end else if (restore_i && cur_q != LVL_W'(IDLE)) begin
      cur_q <= saved_q[cur_q];
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl
  import vpc_pkg::*;
#(
  parameter int unsigned NUM_SLOT = 16,
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned DATA_W   = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  localparam int unsigned LVL_W = $clog2(NUM_SLOT + 2);
  localparam int unsigned IDX_W = $clog2(NUM_SLOT);
  localparam int unsigned CW    = $bits(slot_ctrl_t);

  logic [DATA_W-1:0]               slot_addr_q [NUM_SLOT];
  slot_ctrl_t [NUM_SLOT-1:0]       slot_ctrl_q;
  logic [DATA_W-1:0]               dflt_q;
  logic [DATA_W-1:0]               rdata_q;
  logic [NUM_SLOT+1:0][NUM_SRC-1:0] masks;
  logic [LVL_W-1:0]                cur_lvl;
  logic [LVL_W-1:0]                hit_lvl;
  logic                            hit;

  logic [IDX_W-1:0] idx;
  logic sel_addr, sel_ctrl, sel_vect, sel_dflt, rd_vect, wr_vect;

  assign idx      = addr_i[IDX_W+1:2];
  assign sel_addr = addr_i[ADDR_W-1:IDX_W+2] == BASE_ADDR[ADDR_W-1:IDX_W+2];
  assign sel_ctrl = addr_i[ADDR_W-1:IDX_W+2] == BASE_CTRL[ADDR_W-1:IDX_W+2];
  assign sel_vect = addr_i[ADDR_W-1:2] == OFS_VECT[ADDR_W-1:2];
  assign sel_dflt = addr_i[ADDR_W-1:2] == OFS_DFLT[ADDR_W-1:2];
  assign rd_vect  = req_i && !we_i && sel_vect;
  assign wr_vect  = req_i &&  we_i && sel_vect;

  logic unused_bits;
  assign unused_bits = ^{addr_i[1:0], wdata_i[DATA_W-1:CW]};

  vpc_mask_gen #(.NUM_SLOT(NUM_SLOT), .NUM_SRC(NUM_SRC)) u_mask (
    .ctrl_i  (slot_ctrl_q),
    .masks_o (masks)
  );

  vpc_level_pick #(.NUM_SLOT(NUM_SLOT), .NUM_SRC(NUM_SRC)) u_pick (
    .pend_i  (pend_i),
    .masks_i (masks),
    .cur_i   (cur_lvl),
    .found_o (hit),
    .lvl_o   (hit_lvl),
    .irq_o   (irq_o)
  );

  vpc_prio_stack #(.NUM_SLOT(NUM_SLOT)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .raise_i     (rd_vect && hit),
    .raise_lvl_i (hit_lvl),
    .restore_i   (wr_vect),
    .cur_o       (cur_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SLOT; i++) begin
        slot_addr_q[i] <= '0;
        slot_ctrl_q[i] <= '0;
      end
      dflt_q <= '0;
    end else if (req_i && we_i) begin
      if (sel_addr) slot_addr_q[idx] <= wdata_i;
      if (sel_ctrl) slot_ctrl_q[idx] <= slot_ctrl_t'(wdata_i[CW-1:0]);
      if (sel_dflt) dflt_q           <= wdata_i;
    end
  end

  logic [DATA_W-1:0] vect_val, rd_d;

  // level NUM_SLOT and a failed search both yield the default address
  always_comb begin
    vect_val = dflt_q;
    if (hit && hit_lvl < LVL_W'(NUM_SLOT)) vect_val = slot_addr_q[hit_lvl[IDX_W-1:0]];
  end

  always_comb begin
    rd_d = '0;
    if (sel_addr)      rd_d = slot_addr_q[idx];
    else if (sel_ctrl) rd_d = DATA_W'(slot_ctrl_q[idx]);
    else if (sel_vect) rd_d = vect_val;
    else if (sel_dflt) rd_d = dflt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/vpc_checker.sv
module vpc_checker #(
  parameter int unsigned NUM_SLOT = 16,
  parameter int unsigned NUM_SRC  = 32,
  localparam int unsigned LVL_W   = $clog2(NUM_SLOT + 2),
  localparam int unsigned IDLE    = NUM_SLOT + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] pend_i,
  input logic               req_i,
  input logic               we_i,
  input logic [11:0]        addr_i,
  input logic               irq_o,
  input logic [LVL_W-1:0]   cur_lvl_i
);
  logic va_rd, va_wr;
  assign va_rd = req_i && !we_i && addr_i[11:2] == 10'h00C;
  assign va_wr = req_i &&  we_i && addr_i[11:2] == 10'h00C;

  a_r3_idle_any_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_lvl_i == LVL_W'(IDLE) |-> irq_o == (|pend_i));

  a_r4_read_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    va_rd && irq_o |=> cur_lvl_i < $past(cur_lvl_i));

  a_r5_read_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    va_rd && !irq_o |=> $stable(cur_lvl_i));

  a_r6_write_lowers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    va_wr && cur_lvl_i != LVL_W'(IDLE) |=> cur_lvl_i > $past(cur_lvl_i));

  a_r6_idle_write_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    va_wr && cur_lvl_i == LVL_W'(IDLE) |=> cur_lvl_i == LVL_W'(IDLE));

  a_r8_level_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_lvl_i <= LVL_W'(IDLE));
endmodule

bind vec_prio_ctrl vpc_checker #(.NUM_SLOT(NUM_SLOT), .NUM_SRC(NUM_SRC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pend_i    (pend_i),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .irq_o     (irq_o),
  .cur_lvl_i (cur_lvl)
);

// File: tb/sim_vec_prio_ctrl.sv
`timescale 1ns/1ps
module sim_vec_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pend = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_flag = 1'b0;

  localparam logic [31:0] DEF = 32'hDEF0_0000;

  always #2.5 clk = ~clk;

  vec_prio_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: pops the expected read result the cycle after a read strobe
  always @(posedge clk) rd_flag <= req && !we;
  always @(negedge clk) begin
    if (rd_flag) begin
      logic [31:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s rdata act=%h exp=%h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk); req = 1; we = 0; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); req = 0;
  endtask

  task automatic rd_pend(input logic [31:0] p, input logic [11:0] a,
                         input logic [31:0] e, input string t);
    @(negedge clk); pend = p; req = 1; we = 0; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); req = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq act=%b exp=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_irq(0, "R8 reset irq");
    rd(12'h100, 0, "R8 slot addr clear");
    rd(12'h200, 0, "R8 slot ctrl clear");
    rd(12'h034, 0, "R8 default clear");

    wr(12'h034, DEF);
    wr(12'h100, 32'hA000); wr(12'h200, 32'h23);
    wr(12'h104, 32'hB000); wr(12'h204, 32'h27);
    wr(12'h108, 32'hC000); wr(12'h208, 32'h09);
    rd(12'h204, 32'h27, "R7 ctrl readback");
    rd(12'h104, 32'hB000, "R7 addr readback");
    rd(12'h034, DEF, "R7 default readback");

    pend = 32'h200;
    chk_irq(1, "R3 idle pending");
    rd(12'h030, DEF, "R4 default level");
    chk_irq(0, "R2 disabled slot at level16");
    pend = 32'h280;
    chk_irq(1, "R3 slot source at level16");
    rd(12'h030, 32'hB000, "R4 raise slot1");
    chk_irq(0, "R1 blocked under slot1");
    rd(12'h030, DEF, "R5 no higher");
    chk_irq(0, "R5 level kept");
    pend = 32'h288;
    chk_irq(1, "R1 slot0 preempts");
    rd(12'h030, 32'hA000, "R4 raise slot0");
    chk_irq(0, "R1 top level");

    wr(12'h030, 32'h1234);
    chk_irq(1, "R6 back to slot1");
    wr(12'h030, 32'h0);
    pend = 32'h200;
    chk_irq(0, "R6 back to level16");
    wr(12'h030, 32'h0);
    chk_irq(1, "R6 back to idle");
    wr(12'h030, 32'hFFFF_FFFF);
    chk_irq(1, "R6 idle write noop");
    pend = 0;
    rd(12'h030, DEF, "R5 idle nothing pending");
    pend = 32'h200;
    chk_irq(1, "R5 still idle");

    wr(12'h10C, 32'hD000); wr(12'h20C, 32'h23);
    pend = 32'h8;
    rd(12'h030, 32'hA000, "R10 duplicate source");
    chk_irq(0, "R10 level0 active");
    wr(12'h030, 0);
    chk_irq(1, "R10 restored idle");

    pend = 32'h80;
    rd(12'h030, 32'hB000, "R9 slot1 before remap");
    chk_irq(0, "R9 before remap");
    wr(12'h200, 32'h27);
    chk_irq(1, "R9 remap next cycle");
    rd(12'h030, 32'hA000, "R9 search after remap");
    wr(12'h030, 0); wr(12'h030, 0);

    pend = 0;
    chk_irq(0, "R11 idle quiet");
    rd_pend(32'h8, 12'h030, 32'hD000, "R11 same edge pending");
    chk_irq(0, "R11 level3 active");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R7 reads unanswered act=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule